// File: doc/BRIEF.md
# Even-Modulus Square Wave Generator

This block divides a fast reference clock down to a square wave with an exact 50% duty cycle. A free-running counter steps from zero up to one less than an active modulus and then wraps. The in-phase output is high while the count sits in the lower half of that range, so the output frequency is the reference frequency divided by the modulus. For example, a 60 MHz reference with a modulus of 4000 gives 15 kHz, and the output is high for 2000 reference cycles of each period.

Software sets the modulus through a small synchronous write port. Only even moduli of two or more are accepted. A rejected write leaves the running modulus unchanged and raises a sticky error flag, which software clears with a second write. An accepted value waits in a staging register and is only loaded when the counter wraps, so every period already under way finishes intact.

When the active modulus is a multiple of four, a second output lags the first by a quarter period. The two outputs then form an in-phase and quadrature pair for a mixer's local oscillator. For any other modulus the quadrature output stays low and its valid flag drops. Once set up, the block runs with no further software service.

Top module: `sqwave_gen`

## Requirements
- R1: While enabled, the in-phase output repeats with a period of exactly M reference cycles, where M is the active modulus. The internal count always stays below M.
- R2: The in-phase output is high for exactly M/2 consecutive cycles of each period, starting at count zero, and low for the other M/2 cycles.
- R3: A write to address 0 with an odd value, or with a value below 2, is ignored. It does not change the staged or the active modulus, and from the next cycle `err_flag` is 1.
- R4: A write to address 1 with data bit 0 set clears `err_flag` on the next cycle. A write to address 1 with data bit 0 clear has no effect on it.
- R5: An accepted modulus becomes active only when the counter wraps, or on any cycle while the block is disabled. `mod_cur` always shows the active modulus.
- R6: When the active modulus is a multiple of four, `quad_valid` is 1. The quadrature output is then high for counts from M/4 to 3M/4-1, so it lags the in-phase output by M/4 cycles.
- R7: When the active modulus is not a multiple of four, `quad_valid` is 0 and the quadrature output is low from the following cycle.
- R8: While `en` is low, the counter holds at zero and both outputs are low from the following cycle. After `en` rises, the in-phase output rises on the next cycle.
- R9: After reset, the active modulus and the staged modulus both equal the RESET_MOD parameter (default 4), `err_flag` is 0 and both outputs are low. Both square-wave outputs change only one cycle after the count and the enable that decide them, because each is held in a register.

Reset (`rst`) is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable. While low, the counter is held at zero and the outputs are low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 selects the modulus, 1 selects the control word (bit 0 clears the error flag) |
| wr_data | input | CNT_W | Write data |
| sq_i | output | 1 | In-phase square wave |
| sq_q | output | 1 | Quadrature square wave, lagging by a quarter period |
| quad_valid | output | 1 | High when the active modulus is a multiple of four |
| err_flag | output | 1 | Sticky flag set by a rejected modulus write |
| mod_cur | output | CNT_W | Active modulus |

## Verification
The bench sweeps every even modulus from 2 to 254 on an 8-bit counter. This separates moduli that are multiples of four, where the quadrature output must run, from those that are only even, where it must stay low and the valid flag must drop. Illegal values (0, 1, odd values and the largest odd value) are written to show that the error path leaves the running wave untouched. A modulus change in the middle of a period shows that the old period still completes before the new one begins. Toggling the enable shows that the wave restarts from the same phase each time. Direct edge-to-edge measurements of period, high time and quadrature lag cross-check the per-cycle comparison against the bench's own model.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

   // Register addresses seen on the write port
   typedef enum logic {
      SQW_ADDR_MOD  = 1'b0,
      SQW_ADDR_CTRL = 1'b1
   } sqw_addr_e;

   // Bit of the control word that clears the sticky error flag
   localparam int SQW_CTRL_CLR_BIT = 0;

   // Smallest legal modulus
   localparam int SQW_MIN_MOD = 2;

endpackage

// File: rtl/sqw_modreg.sv
module sqw_modreg
   import sqw_pkg::*;
#(
   parameter int W         = 16,
   parameter int RESET_MOD = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_en,
   input  logic         wr_addr,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] pend_mod,
   output logic         err_flag
);

   localparam logic [W-1:0] RST_VAL = W'(RESET_MOD);
   localparam logic [W-1:0] MIN_VAL = W'(SQW_MIN_MOD);

   logic mod_wr;
   logic ctl_wr;
   logic legal;

   assign mod_wr = wr_en && (sqw_addr_e'(wr_addr) == SQW_ADDR_MOD);
   assign ctl_wr = wr_en && (sqw_addr_e'(wr_addr) == SQW_ADDR_CTRL);
   assign legal  = !wr_data[0] && (wr_data >= MIN_VAL);

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_mod <= RST_VAL;
      end else if (mod_wr && legal) begin
         pend_mod <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         err_flag <= 1'b0;
      end else if (mod_wr && !legal) begin
         err_flag <= 1'b1;
      end else if (ctl_wr && wr_data[SQW_CTRL_CLR_BIT]) begin
         err_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/sqw_counter.sv
module sqw_counter #(
   parameter int W         = 16,
   parameter int RESET_MOD = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] pend_mod,
   output logic [W-1:0] cnt,
   output logic [W-1:0] mod_cur
);

   localparam logic [W-1:0] RST_VAL = W'(RESET_MOD);
   localparam logic [W-1:0] ONE     = W'(1);

   logic at_top;

   assign at_top = (cnt == (mod_cur - ONE));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt     <= '0;
         mod_cur <= RST_VAL;
      end else if (!en) begin
         cnt     <= '0;
         mod_cur <= pend_mod;
      end else if (at_top) begin
         cnt     <= '0;
         mod_cur <= pend_mod;
      end else begin
         cnt     <= cnt + ONE;
      end
   end

endmodule

// File: rtl/sqw_phase.sv
module sqw_phase #(
   parameter int W       = 16,
   parameter bit QUAD_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] mod_cur,
   output logic         sq_i,
   output logic         sq_q,
   output logic         quad_valid
);

   logic [W-1:0] half_pt;

   assign half_pt = mod_cur >> 1;

   always_ff @(posedge clk) begin
      if (rst) begin
         sq_i <= 1'b0;
      end else begin
         sq_i <= en && (cnt < half_pt);
      end
   end

   generate
      if (QUAD_EN) begin : g_quad
         logic [W-1:0] qtr_pt;
         logic [W-1:0] end_pt;
         logic         q_ok;

         assign qtr_pt = mod_cur >> 2;
         assign end_pt = qtr_pt + half_pt;
         assign q_ok   = (mod_cur[1:0] == 2'b00);

         always_ff @(posedge clk) begin
            if (rst) begin
               sq_q <= 1'b0;
            end else begin
               sq_q <= en && q_ok && (cnt >= qtr_pt) && (cnt < end_pt);
            end
         end

         assign quad_valid = q_ok;
      end else begin : g_noquad
         assign sq_q       = 1'b0;
         assign quad_valid = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/sqwave_gen.sv
module sqwave_gen #(
   parameter int CNT_W     = 16,
   parameter int RESET_MOD = 4,
   parameter bit QUAD_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic             sq_i,
   output logic             sq_q,
   output logic             quad_valid,
   output logic             err_flag,
   output logic [CNT_W-1:0] mod_cur
);

   localparam int MAX_MOD = (1 << CNT_W) - 2;

   // Elaboration-time parameter checks
   if (CNT_W < 3 || CNT_W > 31) begin : g_bad_width
      $error("sqwave_gen: CNT_W must lie between 3 and 31");
   end
   if (RESET_MOD < 2 || RESET_MOD > MAX_MOD || (RESET_MOD % 2) != 0) begin : g_bad_reset
      $error("sqwave_gen: RESET_MOD must be even, at least 2 and fit CNT_W");
   end

   logic [CNT_W-1:0] pend_mod;
   logic [CNT_W-1:0] cnt_q;

   sqw_modreg #(
      .W         (CNT_W),
      .RESET_MOD (RESET_MOD)
   ) u_modreg (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .pend_mod (pend_mod),
      .err_flag (err_flag)
   );

   sqw_counter #(
      .W         (CNT_W),
      .RESET_MOD (RESET_MOD)
   ) u_counter (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .pend_mod (pend_mod),
      .cnt      (cnt_q),
      .mod_cur  (mod_cur)
   );

   sqw_phase #(
      .W       (CNT_W),
      .QUAD_EN (QUAD_EN)
   ) u_phase (
      .clk        (clk),
      .rst        (rst),
      .en         (en),
      .cnt        (cnt_q),
      .mod_cur    (mod_cur),
      .sq_i       (sq_i),
      .sq_q       (sq_q),
      .quad_valid (quad_valid)
   );

endmodule

// File: rtl/sqwave_gen_chk.sv
module sqwave_gen_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst,
   input logic         en,
   input logic         wr_en,
   input logic         wr_addr,
   input logic [W-1:0] wr_data,
   input logic         sq_i,
   input logic         sq_q,
   input logic         quad_valid,
   input logic         err_flag,
   input logic [W-1:0] mod_cur,
   input logic [W-1:0] cnt
);

   localparam logic [W-1:0] ONE = W'(1);
   localparam logic [W-1:0] TWO = W'(2);

   // R1: the count never reaches the active modulus
   assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
      cnt < mod_cur);

   // R3: the active modulus is always legal
   assert_mod_legal_R3: assert property (@(posedge clk) disable iff (rst)
      (!mod_cur[0] && mod_cur >= TWO));

   // R3: an illegal modulus write raises the error flag
   assert_err_set_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_addr && (wr_data[0] || wr_data < TWO)) |=> err_flag);

   // R4: the clear command drops the flag unless a rejected write coincides
   assert_err_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr && wr_data[0]) |=> !err_flag);

   // R5: the active modulus changes only at a wrap or while disabled
   assert_mod_at_wrap_R5: assert property (@(posedge clk) disable iff (rst)
      !$stable(mod_cur) |-> ((!$past(en)) || ($past(cnt) == $past(mod_cur) - ONE)));

   // R7: no quadrature wave without a multiple-of-four modulus
   assert_quad_low_R7: assert property (@(posedge clk) disable iff (rst)
      !quad_valid |=> !sq_q);

   // R8: disabled means zero count and quiet outputs on the next cycle
   assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      !en |=> (!sq_i && !sq_q && cnt == '0));

endmodule

bind sqwave_gen sqwave_gen_chk #(.W(CNT_W)) u_sqwave_gen_chk (
   .clk        (clk),
   .rst        (rst),
   .en         (en),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .sq_i       (sq_i),
   .sq_q       (sq_q),
   .quad_valid (quad_valid),
   .err_flag   (err_flag),
   .mod_cur    (mod_cur),
   .cnt        (cnt_q)
);

// File: tb/sqwave_gen_bench.sv
module sqwave_gen_bench;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam int RST_MOD    = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         en = 1'b0;
   logic         wr_en = 1'b0;
   logic         wr_addr = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         sq_i;
   logic         sq_q;
   logic         quad_valid;
   logic         err_flag;
   logic [W-1:0] mod_cur;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sqwave_gen #(
      .CNT_W     (W),
      .RESET_MOD (RST_MOD),
      .QUAD_EN   (1'b1)
   ) u_sqwave_gen (
      .clk        (clk),
      .rst        (rst),
      .en         (en),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .sq_i       (sq_i),
      .sq_q       (sq_q),
      .quad_valid (quad_valid),
      .err_flag   (err_flag),
      .mod_cur    (mod_cur)
   );

   // Reference model built from the requirements
   int m_cnt, m_mod, m_pend;
   bit m_err, e_i, e_q;

   always @(posedge clk) begin
      if (rst) begin
         m_cnt  <= 0;
         m_mod  <= RST_MOD;
         m_pend <= RST_MOD;
         m_err  <= 1'b0;
         e_i    <= 1'b0;
         e_q    <= 1'b0;
      end else begin
         // R2 / R6 / R8: outputs follow the previous count
         e_i <= en && (m_cnt < m_mod / 2);
         e_q <= en && (m_mod % 4 == 0) && (m_cnt >= m_mod / 4) && (m_cnt < m_mod / 4 + m_mod / 2);
         // R3 / R4: write port
         if (wr_en && !wr_addr) begin
            if (wr_data[0] == 1'b0 && int'(wr_data) >= 2) m_pend <= int'(wr_data);
            else m_err <= 1'b1;
         end else if (wr_en && wr_addr && wr_data[0]) begin
            m_err <= 1'b0;
         end
         // R1 / R5 / R8: counter
         if (!en || m_cnt == m_mod - 1) begin
            m_cnt <= 0;
            m_mod <= m_pend;
         end else begin
            m_cnt <= m_cnt + 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         check(sq_i == e_i, "R2 sq_i", sq_i, e_i);
         check(sq_q == e_q, "R6 sq_q", sq_q, e_q);
         check(quad_valid == (m_mod % 4 == 0), "R7 quad_valid", quad_valid, m_mod % 4 == 0);
         check(err_flag == m_err, "R3 err_flag", err_flag, m_err);
         check(int'(mod_cur) == m_mod, "R5 mod_cur", mod_cur, m_mod);
      end
   end

   task automatic wr(input bit a, input int d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = W'(d);
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // Wait for a rising edge of sq_i (sampled at negedge)
   task automatic wait_rise_i(output int waited);
      bit prev;
      prev = sq_i;
      waited = 0;
      forever begin
         @(negedge clk);
         waited++;
         if (sq_i && !prev) break;
         prev = sq_i;
      end
   endtask

   task automatic measure(input int m);
      int w, per, hi, lag;
      bit qseen;
      wait_rise_i(w);
      per = 0; hi = 0; lag = -1; qseen = 1'b0;
      for (int k = 0; k < m; k++) begin
         if (sq_i) hi++;
         if (sq_q && !qseen) begin
            lag = k;
            qseen = 1'b1;
         end
         per++;
         @(negedge clk);
      end
      check(sq_i && (hi == m / 2), "R2 high time", hi, m / 2);
      check(per == m && sq_i, "R1 period", per, m);
      if (m % 4 == 0) check(lag == m / 4, "R6 quad lag", lag, m / 4);
      else check(!qseen, "R7 quad silent", qseen, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 180000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      // R9: reset state
      check(sq_i == 1'b0 && sq_q == 1'b0, "R9 outputs low", {sq_i, sq_q}, 0);
      check(int'(mod_cur) == RST_MOD, "R9 reset modulus", mod_cur, RST_MOD);
      check(err_flag == 1'b0, "R9 err clear", err_flag, 0);
      @(negedge clk);
      rst = 1'b0;
      cmp_on = 1'b1;
      idle(4);
      // R8: disabled keeps outputs low
      check(sq_i == 1'b0, "R8 idle low", sq_i, 0);
      en = 1'b1;
      @(negedge clk);
      check(sq_i == 1'b1, "R8 rises after enable", sq_i, 1);
      idle(10);
      // R1 R2 R6 R7: sweep of every even modulus
      for (int m = 2; m <= 254; m += 2) begin
         wr(1'b0, m);
         idle(3 * m + 4);
      end
      // Direct measurements
      wr(1'b0, 6);  idle(20); measure(6);
      wr(1'b0, 8);  idle(20); measure(8);
      wr(1'b0, 40); idle(90); measure(40);
      wr(1'b0, 2);  idle(50); measure(2);
      // R3: illegal writes are ignored
      wr(1'b0, 20); idle(30);
      wr(1'b0, 7);
      check(err_flag == 1'b1, "R3 odd sets flag", err_flag, 1);
      idle(25);
      check(int'(mod_cur) == 20, "R3 modulus kept", mod_cur, 20);
      measure(20);
      wr(1'b1, 0);
      check(err_flag == 1'b1, "R4 bit0 clear no effect", err_flag, 1);
      wr(1'b1, 1);
      check(err_flag == 1'b0, "R4 clear", err_flag, 0);
      wr(1'b0, 0);
      check(err_flag == 1'b1, "R3 zero sets flag", err_flag, 1);
      wr(1'b1, 1);
      wr(1'b0, 1);
      check(err_flag == 1'b1, "R3 one sets flag", err_flag, 1);
      wr(1'b1, 1);
      wr(1'b0, 255);
      check(err_flag == 1'b1, "R3 max odd sets flag", err_flag, 1);
      idle(25);
      check(int'(mod_cur) == 20, "R3 modulus still kept", mod_cur, 20);
      wr(1'b1, 1);
      // R5: change in the middle of a period
      wr(1'b0, 100); idle(250);
      wr(1'b0, 12);
      check(int'(mod_cur) == 100, "R5 not yet applied", mod_cur, 100);
      idle(120);
      check(int'(mod_cur) == 12, "R5 applied after wrap", mod_cur, 12);
      // R8: enable toggling mid period
      for (int k = 1; k < 9; k++) begin
         idle(k);
         en = 1'b0;
         @(negedge clk);
         check(sq_i == 1'b0 && sq_q == 1'b0, "R8 off quiet", {sq_i, sq_q}, 0);
         idle(2);
         en = 1'b1;
         @(negedge clk);
         check(sq_i == 1'b1, "R8 restart phase", sq_i, 1);
      end
      idle(30);
      cmp_on = 1'b0;
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule